// File: doc/BRIEF.md
# Presettable Cascadable Up-Counter Stage

This block is a four-bit synchronous up-counter. One build-time switch makes it count in decimal (0 to 9) or in binary (0 to 15). A second switch makes its active-low clear either asynchronous or sampled on the clock. On any rising edge the block does one of four things: it clears, it loads a parallel word, it advances, or it holds its value. The choice follows a fixed priority. Counting needs two enables to be high together. The first enable goes to every stage of a chain. The second is a ripple-through enable, and it also gates the terminal-count flag.

Several stages can be chained to build a wider counter. The terminal-count flag of a lower stage drives the ripple-through enable of the stage above it. All stages share the other enable. The upper stage then advances once for each full cycle of the stage below, with no glue logic between stages. In decimal mode a load may place an undefined code (10 to 15) in the register. The counter then returns to the legal range within two counting edges, along a fixed path.

Top module: `pcnt_stage`

## Requirements
- R1: A low `clr_n` on a rising edge makes `q` equal to 0. This takes priority over `ld_n`, `en_p` and `en_t`. With `ASYNC_CLR=0` the clear acts only on that edge.
- R2: With `ASYNC_CLR=1`, `q` goes to 0 as soon as `clr_n` goes low, without waiting for a clock edge. A stage built with `ASYNC_CLR=0` keeps its value until the next rising edge.
- R3: When `clr_n` is high and `ld_n` is low, `q` takes the value of `din` on the rising edge, whatever the levels of `en_p` and `en_t`.
- R4: When `clr_n` and `ld_n` are both high, `q` advances on the rising edge only if `en_p` and `en_t` are both high. If either enable is low, `q` is unchanged.
- R5: `tc` is combinational. It is 1 exactly when `en_t` is 1 and `q` holds the terminal value: 9 when `MOD10=1`, 15 when `MOD10=0`. `en_p` has no effect on `tc`.
- R6: While counting, the terminal value is followed by 0: 9 goes to 0 in decimal mode, and 15 goes to 0 in binary mode.
- R7: With `MOD10=1`, codes 10 to 15 can be loaded and never raise `tc`. While counting, they step 10→11→6, 12→13→4 and 14→15→2.
- R8: An undefined decimal code is held unchanged, like any other value, while counting is inhibited.
- R9: In a chain, the lower stage's `tc` drives the upper stage's `en_t`, and both stages share `en_p`, `ld_n` and `clr_n`. The upper stage then advances exactly once per full cycle of the lower stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all synchronous changes occur on its rising edge |
| clr_n | input | 1 | Active-low clear, asynchronous or synchronous per `ASYNC_CLR` |
| ld_n | input | 1 | Active-low parallel load enable |
| din | input | 4 | Parallel load value |
| en_p | input | 1 | Count enable shared across a chain |
| en_t | input | 1 | Ripple-through count enable; also gates `tc` |
| q | output | 4 | Present count |
| tc | output | 1 | Terminal-count flag |

## Verification
The bench builds the block in three configurations:
- a decimal stage with a clock-sampled clear, which exposes every undefined code and its recovery path;
- a binary stage with an immediate clear, which allows a clear to be asserted mid-cycle and checked against the clock-sampled stage;
- a pair of binary stages with sampled clears, wired as a chain, whose upper count shows the carry across forty counting edges.

All four instances receive the same stimulus. Each is compared against its own reference model on every cycle.

// File: rtl/pcnt_pkg.sv
package pcnt_pkg;
  localparam int CNT_W = 4;
  localparam int DEC_TOP = 9;
  localparam int BIN_TOP = (1 << CNT_W) - 1;

  typedef logic [CNT_W-1:0] cnt_t;

  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_LOAD  = 2'd1,
    OP_COUNT = 2'd2,
    OP_CLEAR = 2'd3
  } op_e;

  // Terminal value of the selected modulus.
  function automatic cnt_t term_value(input bit mod10);
    return mod10 ? cnt_t'(DEC_TOP) : cnt_t'(BIN_TOP);
  endfunction

  function automatic logic at_term(input cnt_t v, input bit mod10);
    return v == term_value(mod10);
  endfunction

  // Successor of v while counting; undefined decimal codes fold back.
  function automatic cnt_t step_count(input cnt_t v, input bit mod10);
    cnt_t r;
    r = v + cnt_t'(1);
    if (mod10) begin
      case (v)
        cnt_t'(9):  r = '0;
        cnt_t'(11): r = cnt_t'(6);
        cnt_t'(13): r = cnt_t'(4);
        cnt_t'(15): r = cnt_t'(2);
        default:    r = v + cnt_t'(1);
      endcase
    end
    return r;
  endfunction
endpackage

// File: rtl/pcnt_ctrl.sv
module pcnt_ctrl
  import pcnt_pkg::*;
(
  input  logic clr_n,
  input  logic ld_n,
  input  logic en_p,
  input  logic en_t,
  output op_e  op
);
  // Priority: clear, then load, then count, else hold.
  always_comb begin
    if (!clr_n)            op = OP_CLEAR;
    else if (!ld_n)        op = OP_LOAD;
    else if (en_p && en_t) op = OP_COUNT;
    else                   op = OP_HOLD;
  end
endmodule

// File: rtl/pcnt_next.sv
module pcnt_next
  import pcnt_pkg::*;
#(
  parameter bit MOD10 = 1'b1
) (
  input  op_e  op,
  input  cnt_t cur,
  input  cnt_t din,
  output cnt_t nxt
);
  always_comb begin
    unique case (op)
      OP_CLEAR: nxt = '0;
      OP_LOAD:  nxt = din;
      OP_COUNT: nxt = step_count(cur, MOD10);
      default:  nxt = cur;
    endcase
  end
endmodule

// File: rtl/pcnt_state.sv
module pcnt_state
  import pcnt_pkg::*;
#(
  parameter bit ASYNC_CLR = 1'b0
) (
  input  logic clk,
  input  logic clr_n,
  input  cnt_t nxt,
  output cnt_t q
);
  generate
    if (ASYNC_CLR) begin : g_async
      always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) q <= '0;
        else        q <= nxt;
      end
    end else begin : g_sync
      always_ff @(posedge clk) begin
        if (!clr_n) q <= '0;
        else        q <= nxt;
      end
    end
  endgenerate
endmodule

// File: rtl/pcnt_stage.sv
module pcnt_stage
  import pcnt_pkg::*;
#(
  parameter bit MOD10     = 1'b1,
  parameter bit ASYNC_CLR = 1'b0
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             ld_n,
  input  logic [CNT_W-1:0] din,
  input  logic             en_p,
  input  logic             en_t,
  output logic [CNT_W-1:0] q,
  output logic             tc
);
  op_e  op;
  cnt_t nxt;
  logic cnt_go;   // count event, brought out for the checker
  logic at_top;   // register sits at the terminal value

  pcnt_ctrl u_ctrl (
    .clr_n (clr_n),
    .ld_n  (ld_n),
    .en_p  (en_p),
    .en_t  (en_t),
    .op    (op)
  );

  pcnt_next #(.MOD10(MOD10)) u_next (
    .op  (op),
    .cur (q),
    .din (din),
    .nxt (nxt)
  );

  pcnt_state #(.ASYNC_CLR(ASYNC_CLR)) u_state (
    .clk   (clk),
    .clr_n (clr_n),
    .nxt   (nxt),
    .q     (q)
  );

  assign cnt_go = (op == OP_COUNT);
  assign at_top = at_term(q, MOD10);
  assign tc     = en_t & at_top;
endmodule

// File: rtl/pcnt_checker.sv
module pcnt_checker
  import pcnt_pkg::*;
#(
  parameter bit MOD10     = 1'b1,
  parameter bit ASYNC_CLR = 1'b0
) (
  input logic clk,
  input logic clr_n,
  input logic ld_n,
  input cnt_t din,
  input logic en_p,
  input logic en_t,
  input cnt_t q,
  input logic tc,
  input logic cnt_go
);
  localparam cnt_t TOP = term_value(MOD10);
  localparam bit   IMM = ASYNC_CLR;

  p_clear_r1: assert property (@(posedge clk) !clr_n |=> (q == '0 || IMM == 1'b0 || IMM == 1'b1) && q == '0);

  p_load_r3: assert property (@(posedge clk) disable iff (!clr_n)
    !ld_n |=> q == $past(din));

  p_hold_r4: assert property (@(posedge clk) disable iff (!clr_n)
    (ld_n && !(en_p && en_t)) |=> $stable(q));

  p_tc_gate_r5: assert property (@(posedge clk) disable iff (!clr_n)
    !en_t |-> !tc);

  p_wrap_r6: assert property (@(posedge clk) disable iff (!clr_n)
    (cnt_go && q == TOP) |=> q == '0);

  generate
    if (MOD10) begin : g_dec
      p_no_tc_illegal_r7: assert property (@(posedge clk) disable iff (!clr_n)
        (q > cnt_t'(9)) |-> !tc);
      p_fold_r7: assert property (@(posedge clk) disable iff (!clr_n)
        (cnt_go && q == cnt_t'(11)) |=> q == cnt_t'(6));
    end
  endgenerate
endmodule

bind pcnt_stage pcnt_checker #(.MOD10(MOD10), .ASYNC_CLR(ASYNC_CLR)) u_chk (
  .clk    (clk),
  .clr_n  (clr_n),
  .ld_n   (ld_n),
  .din    (din),
  .en_p   (en_p),
  .en_t   (en_t),
  .q      (q),
  .tc     (tc),
  .cnt_go (cnt_go)
);

// File: tb/pcnt_stage_test.sv
module pcnt_stage_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       clr_n = 1'b0;
  logic       ld_n = 1'b1;
  logic [3:0] din = 4'd0;
  logic       en_p = 1'b0;
  logic       en_t = 1'b0;

  logic [3:0] q_a, q_b, q_l, q_h;
  logic       tc_a, tc_b, tc_l, tc_h;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // Decimal, clock-sampled clear
  pcnt_stage #(.MOD10(1'b1), .ASYNC_CLR(1'b0)) uut (
    .clk(clk), .clr_n(clr_n), .ld_n(ld_n), .din(din),
    .en_p(en_p), .en_t(en_t), .q(q_a), .tc(tc_a));

  // Binary, immediate clear
  pcnt_stage #(.MOD10(1'b0), .ASYNC_CLR(1'b1)) u_bin (
    .clk(clk), .clr_n(clr_n), .ld_n(ld_n), .din(din),
    .en_p(en_p), .en_t(en_t), .q(q_b), .tc(tc_b));

  // Two-stage binary chain
  pcnt_stage #(.MOD10(1'b0), .ASYNC_CLR(1'b0)) u_lo (
    .clk(clk), .clr_n(clr_n), .ld_n(ld_n), .din(din),
    .en_p(en_p), .en_t(en_t), .q(q_l), .tc(tc_l));
  pcnt_stage #(.MOD10(1'b0), .ASYNC_CLR(1'b0)) u_hi (
    .clk(clk), .clr_n(clr_n), .ld_n(ld_n), .din(din),
    .en_p(en_p), .en_t(tc_l), .q(q_h), .tc(tc_h));

  typedef struct packed {
    logic [3:0] qa; logic ta;
    logic [3:0] qb; logic tb;
    logic [3:0] ql; logic [3:0] qh; logic th;
  } exp_t;

  exp_t  sb[$];
  string tags[$];
  logic [3:0] m_a = 0, m_b = 0, m_l = 0, m_h = 0;

  function automatic logic [3:0] ref_next(logic [3:0] v, bit dec, logic c,
                                          logic l, logic [3:0] d, logic go);
    if (!c) return 4'd0;
    if (!l) return d;
    if (!go) return v;
    if (!dec) return v + 4'd1;
    if (v < 4'd9) return v + 4'd1;
    if (v == 4'd9) return 4'd0;
    if (!v[0]) return v + 4'd1;
    return 4'(17 - int'(v));
  endfunction

  function automatic logic ref_tc(logic [3:0] v, bit dec, logic t);
    return t && (v == (dec ? 4'd9 : 4'd15));
  endfunction

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(string tag, logic c, logic l, logic [3:0] d, logic p, logic t);
    logic lo_carry;
    exp_t e;
    @(negedge clk);
    clr_n = c; ld_n = l; din = d; en_p = p; en_t = t;
    lo_carry = ref_tc(m_l, 0, t);
    m_a = ref_next(m_a, 1, c, l, d, p & t);
    m_b = ref_next(m_b, 0, c, l, d, p & t);
    m_h = ref_next(m_h, 0, c, l, d, p & lo_carry);
    m_l = ref_next(m_l, 0, c, l, d, p & t);
    e.qa = m_a; e.ta = ref_tc(m_a, 1, t);
    e.qb = m_b; e.tb = ref_tc(m_b, 0, t);
    e.ql = m_l; e.qh = m_h; e.th = ref_tc(m_h, 0, ref_tc(m_l, 0, t));
    sb.push_back(e);
    tags.push_back(tag);
  endtask

  // Monitor: compares one expected item per edge, after outputs settle.
  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      exp_t  e;
      string tg;
      e  = sb.pop_front();
      tg = tags.pop_front();
      chk({tg, " dec q"}, q_a, e.qa);
      chk({tg, " dec tc R5"}, tc_a, e.ta);
      chk({tg, " bin q"}, q_b, e.qb);
      chk({tg, " bin tc R5"}, tc_b, e.tb);
      chk({tg, " chain lo R9"}, q_l, e.ql);
      chk({tg, " chain hi R9"}, q_h, e.qh);
      chk({tg, " chain hi tc R9"}, tc_h, e.th);
    end
  end

  task automatic drain();
    wait (sb.size() == 0);
    #2;
  endtask

  initial begin
    // R1: clear beats load and enables
    step("R1 reset", 0, 1, 4'd0, 0, 0);
    step("R1 clear over load", 0, 0, 4'd6, 1, 1);
    // R3: load with enables low
    step("R3 load", 1, 0, 4'd7, 0, 0);
    // R4/R6: count through the wrap of the decimal stage
    for (int i = 0; i < 5; i++) step("R6 count", 1, 1, 4'd0, 1, 1);
    // R5: tc with en_p low, then en_t low
    step("R3 load nine", 1, 0, 4'd9, 0, 1);
    step("R5 hold en_p low", 1, 1, 4'd0, 0, 1);
    step("R4 hold en_t low", 1, 1, 4'd0, 1, 0);
    // R6: binary wrap; decimal fold from 15
    step("R3 load 15", 1, 0, 4'd15, 1, 1);
    step("R6 wrap", 1, 1, 4'd0, 1, 1);
    step("R6 wrap next", 1, 1, 4'd0, 1, 1);
    // R7/R8: every undefined decimal code
    for (int v = 10; v < 16; v++) begin
      step("R7 load code", 1, 0, 4'(v), 0, 1);
      step("R8 hold code", 1, 1, 4'd0, 0, 1);
      step("R8 hold code", 1, 1, 4'd0, 1, 0);
      step("R7 recover", 1, 1, 4'd0, 1, 1);
      step("R7 recover", 1, 1, 4'd0, 1, 1);
    end
    drain();
    // R2: mid-cycle clear
    step("R3 load five", 1, 0, 4'd5, 0, 0);
    drain();
    @(negedge clk);
    clr_n = 1'b0;
    #1;
    chk("R2 immediate clear", q_b, 0);
    chk("R2 sampled clear waits", q_a, 5);
    m_a = 0; m_b = 0; m_l = 0; m_h = 0;
    // R9: chain over forty counts
    step("R1 clear", 0, 1, 4'd0, 0, 0);
    for (int i = 0; i < 40; i++) step("R9 chain count", 1, 1, 4'd0, 1, 1);
    step("R4 hold", 1, 1, 4'd0, 0, 1);
    drain();
    chk("R9 upper after 40", q_h, 2);
    chk("R9 lower after 40", q_l, 8);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule